// File: doc/BRIEF.md
# Register Write Packet Packer

This block sits between a producer of register writes and a command-stream DMA engine. Each incoming request carries a byte address and a 32-bit data word. The block folds the address into a one-byte register index and collects writes in groups of four. When a group is complete it emits five 32-bit words. The first is a header word that carries the four indices. The other four are the data words, in the same order as their indices.

Two address windows are accepted, each 512 bytes wide and word aligned. The lower window, based at 0x1C00, yields indices 0x00 to 0x7F. The upper window, based at 0x2C00, yields the same offsets with bit 7 set. Any other address, and any address that is not word aligned, is refused: an error pulse is raised and the write is dropped.

A flush request closes a partly collected group. The empty slots are filled with writes to a padding register at 0x1C54, with zero data, and the last word of that group is marked. Input and output both use a valid/ready handshake. No new request is taken while a group is being sent.

Top module: `regpack_top`

## Requirements
- R1: After reset, out_valid, out_last and err_pulse are low and in_ready is high.
- R2: A write to an aligned address A with 0x1C00 <= A <= 0x1DFF gets the index (A - 0x1C00) >> 2, a value in the range 0x00 to 0x7F.
- R3: A write to an aligned address A with 0x2C00 <= A <= 0x2DFF gets the index ((A - 0x2C00) >> 2) | 0x80, so bit 7 marks the upper window.
- R4: In the header word, the index of the group's first write sits in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R5: Each group leaves as exactly five words: the header, then the four data words in arrival order.
- R6: No output word appears until the fourth accepted valid write of a group, or until a flush that finds pending writes. While writes are being collected, in_ready stays high.
- R7: A write whose address is outside both windows, or has a non-zero value in bits [1:0], is still accepted. err_pulse is high in the cycle after the write is accepted, and the write adds nothing to the group being collected. Valid writes never raise err_pulse.
- R8: A flush that finds one to three pending writes fills each remaining slot with index 0x15 (the padding register 0x1C54) and data zero. The group is then sent, with out_last high on its fifth word only.
- R9: A flush that finds no pending writes produces no output.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last stay unchanged.
- R11: in_ready is low in every cycle in which out_valid is high.
- R12: A group completed by its fourth write without a flush is sent with out_last low on all five words. A flush given in the same cycle as the fourth write sets out_last on that group's fifth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A write request is present |
| in_ready | output | 1 | The block accepts a request or a flush this cycle |
| in_addr | input | 16 | Register byte address |
| in_data | input | 32 | Register data word |
| flush | input | 1 | Close the partial group (taken when in_ready is high) |
| out_valid | output | 1 | An output word is present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Header or data word |
| out_last | output | 1 | Fifth word of a group closed by a flush |
| err_pulse | output | 1 | The previous accepted write had an invalid address |

## Verification
The hardest cases to reach are those where a flush or a refused address lands on a group in a given fill state. Examples are a flush in the same cycle as the fourth write, and a bad write that comes with a flush while two writes are pending. A second hard case is holding the output under backpressure at each of the five word positions. The stimulus first sweeps every aligned address in both windows, with bad addresses mixed into groups at positions that keep shifting. It then drives a fixed series of flushes at fill levels 0, 1, 2, 3 and 4, one of them together with a bad write. Throughout, out_ready follows a pattern that is either always high, low every third cycle, or pseudo-random.

// File: rtl/regpack_pkg.sv
package regpack_pkg;

  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_SEND   = 1'b1
  } pack_state_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/regpack_xlate.sv
module regpack_xlate #(
  parameter int          ADDR_W  = 16,
  parameter int          IDX_W   = 8,
  parameter int unsigned LO_BASE = 'h1C00,
  parameter int unsigned HI_BASE = 'h2C00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              ok
);
  import regpack_pkg::*;

  // one window covers 2^(IDX_W-1) word registers
  localparam int unsigned SPAN = WORD_BYTES << (IDX_W - 1);

  logic [31:0]      a32;
  logic             in_lo;
  logic             in_hi;
  logic             aligned;
  logic [IDX_W-2:0] off_lo;
  logic [IDX_W-2:0] off_hi;

  always_comb begin
    a32     = 32'(addr);
    in_lo   = (a32 >= LO_BASE) && (a32 < LO_BASE + SPAN);
    in_hi   = (a32 >= HI_BASE) && (a32 < HI_BASE + SPAN);
    aligned = (addr[1:0] == 2'b00);
    off_lo  = (IDX_W-1)'((a32 - LO_BASE) >> 2);
    off_hi  = (IDX_W-1)'((a32 - HI_BASE) >> 2);
    ok      = aligned && (in_lo || in_hi);
    idx     = in_lo ? {1'b0, off_lo} : {1'b1, off_hi};
  end

endmodule

// File: rtl/regpack_ctrl.sv
module regpack_ctrl
  import regpack_pkg::*;
#(
  parameter int GRP_N  = 4,
  parameter int SLOT_W = 2,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              addr_ok,
  input  logic              flush,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              err_pulse,
  output logic [BEAT_W-1:0] beat,
  output logic [GRP_N-1:0]  slot_wr,
  output logic [GRP_N-1:0]  slot_pad
);

  pack_state_e       st_q, st_n;
  logic [SLOT_W-1:0] cnt_q, cnt_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              lastgrp_q, lastgrp_n;
  logic              err_q, err_n;

  logic              take;
  logic              good;
  logic              flush_now;
  logic              full;
  logic              close;
  logic [SLOT_W:0]   cnt_after;

  // next-state logic
  always_comb begin
    in_ready  = (st_q == ST_GATHER);
    take      = in_valid && in_ready;
    good      = take && addr_ok;
    flush_now = flush && in_ready;
    cnt_after = {1'b0, cnt_q} + (SLOT_W+1)'(good);
    full      = good && (cnt_q == SLOT_W'(GRP_N - 1));
    close     = full || (flush_now && (cnt_after != '0));

    for (int i = 0; i < GRP_N; i++) begin
      slot_wr[i]  = good && (cnt_q == SLOT_W'(i));
      slot_pad[i] = close && ((SLOT_W+1)'(i) >= cnt_after);
    end

    st_n      = st_q;
    cnt_n     = cnt_q;
    beat_n    = beat_q;
    lastgrp_n = lastgrp_q;
    err_n     = take && !addr_ok;

    unique case (st_q)
      ST_GATHER: begin
        if (close) begin
          st_n      = ST_SEND;
          cnt_n     = '0;
          beat_n    = '0;
          lastgrp_n = flush_now;
        end else if (good) begin
          cnt_n = cnt_q + SLOT_W'(1);
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          if (beat_q == BEAT_W'(GRP_N)) begin
            st_n      = ST_GATHER;
            lastgrp_n = 1'b0;
          end else begin
            beat_n = beat_q + BEAT_W'(1);
          end
        end
      end
      default: st_n = ST_GATHER;
    endcase

    out_valid = (st_q == ST_SEND);
    out_last  = out_valid && lastgrp_q && (beat_q == BEAT_W'(GRP_N));
    err_pulse = err_q;
    beat      = beat_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_GATHER;
      cnt_q     <= '0;
      beat_q    <= '0;
      lastgrp_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      beat_q    <= beat_n;
      lastgrp_q <= lastgrp_n;
      err_q     <= err_n;
    end
  end

endmodule

// File: rtl/regpack_slots.sv
module regpack_slots #(
  parameter int GRP_N  = 4,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic [GRP_N-1:0]  slot_wr,
  input  logic [GRP_N-1:0]  slot_pad,
  input  logic [IDX_W-1:0]  new_idx,
  input  logic [DATA_W-1:0] new_data,
  input  logic [IDX_W-1:0]  pad_idx,
  input  logic [BEAT_W-1:0] beat,
  output logic [DATA_W-1:0] word
);

  logic [IDX_W-1:0]  idx_q  [GRP_N];
  logic [DATA_W-1:0] data_q [GRP_N];
  logic [DATA_W-1:0] header;

  for (genvar g = 0; g < GRP_N; g++) begin : g_slot
    logic             en;
    logic [IDX_W-1:0] idx_d;
    logic [DATA_W-1:0] data_d;

    always_comb begin
      en     = slot_wr[g] || slot_pad[g];
      idx_d  = slot_wr[g] ? new_idx  : pad_idx;
      data_d = slot_wr[g] ? new_data : '0;
    end

    // payload registers: clock enable, no reset
    always_ff @(posedge clk) begin
      if (en) begin
        idx_q[g]  <= idx_d;
        data_q[g] <= data_d;
      end
    end

    assign header[g*IDX_W +: IDX_W] = idx_q[g];
  end

  always_comb begin
    word = header;
    for (int i = 0; i < GRP_N; i++) begin
      if (beat == BEAT_W'(i + 1)) word = data_q[i];
    end
  end

endmodule

// File: rtl/regpack_top.sv
module regpack_top
  import regpack_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          GRP_N    = 4,
  parameter int unsigned LO_BASE  = 'h1C00,
  parameter int unsigned HI_BASE  = 'h2C00,
  parameter int unsigned PAD_ADDR = 'h1C54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              err_pulse
);

  localparam int IDX_W  = DATA_W / GRP_N;
  localparam int SLOT_W = $clog2(GRP_N);
  localparam int BEAT_W = $clog2(GRP_N + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [IDX_W-1:0]  in_idx;
  logic              in_ok;
  logic [IDX_W-1:0]  pad_raw;
  logic              pad_ok;
  logic [IDX_W-1:0]  pad_idx;
  logic [BEAT_W-1:0] beat;
  logic [GRP_N-1:0]  slot_wr;
  logic [GRP_N-1:0]  slot_pad;

  regpack_xlate #(
    .ADDR_W (ADDR_W), .IDX_W (IDX_W),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) i_xlate_in (
    .addr(in_addr), .idx(in_idx), .ok(in_ok)
  );

  regpack_xlate #(
    .ADDR_W (ADDR_W), .IDX_W (IDX_W),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) i_xlate_pad (
    .addr(ADDR_W'(PAD_ADDR)), .idx(pad_raw), .ok(pad_ok)
  );

  assign pad_idx = pad_ok ? pad_raw : '0;

  regpack_ctrl #(
    .GRP_N(GRP_N), .SLOT_W(SLOT_W), .BEAT_W(BEAT_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (in_valid),
    .addr_ok  (in_ok),
    .flush    (flush),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_last (out_last),
    .err_pulse(err_pulse),
    .beat     (beat),
    .slot_wr  (slot_wr),
    .slot_pad (slot_pad)
  );

  regpack_slots #(
    .GRP_N(GRP_N), .IDX_W(IDX_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)
  ) i_slots (
    .clk     (clk),
    .slot_wr (slot_wr),
    .slot_pad(slot_pad),
    .new_idx (in_idx),
    .new_data(in_data),
    .pad_idx (pad_idx),
    .beat    (beat),
    .word    (out_data)
  );

endmodule

// File: rtl/regpack_chk.sv
module regpack_chk #(
  parameter int DATA_W = 32,
  parameter int GRP_N  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              flush,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              err_pulse
);

  localparam int BW = $clog2(GRP_N + 1);

  logic [BW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (out_valid && out_ready) begin
      if (pos_q == BW'(GRP_N)) pos_q <= '0;
      else                     pos_q <= pos_q + BW'(1);
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid && in_ready));

  a_r8_last_fifth: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && pos_q == BW'(GRP_N)));

  a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_ready && (in_valid || flush)));

endmodule

bind regpack_top regpack_chk #(.DATA_W(DATA_W), .GRP_N(GRP_N)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .flush    (flush),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .err_pulse(err_pulse)
);

// File: tb/test_regpack_top.sv
module test_regpack_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_MAX    = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_addr;
  logic [31:0] in_data;
  logic        flush;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_last;
  logic        err_pulse;

  regpack_top i_regpack_top (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int rmode  = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] exp_w [EXP_MAX];
  logic        exp_l [EXP_MAX];
  int wr_n = 0;
  int rd_n = 0;

  logic [7:0]  p_idx [4];
  logic [31:0] p_dat [4];
  int          p_n = 0;

  logic        held = 1'b0;
  logic [31:0] held_w;
  logic        held_l;

  function automatic bit addr_good(int a);
    return ((a & 3) == 0) &&
           ((a >= 'h1C00 && a <= 'h1DFF) || (a >= 'h2C00 && a <= 'h2DFF));
  endfunction

  function automatic logic [7:0] idx_of(int a);
    if (a >= 'h1C00 && a <= 'h1DFF) return 8'((a - 'h1C00) >> 2);       // R2
    return 8'(((a - 'h2C00) >> 2) | 'h80);                              // R3
  endfunction

  task automatic push_group(bit last);
    exp_w[wr_n] = {p_idx[3], p_idx[2], p_idx[1], p_idx[0]};             // R4
    exp_l[wr_n] = 1'b0;
    wr_n++;
    for (int i = 0; i < 4; i++) begin
      exp_w[wr_n] = p_dat[i];
      exp_l[wr_n] = (i == 3) ? last : 1'b0;
      wr_n++;
    end
    p_n = 0;
  endtask

  task automatic model(bit wv, int a, logic [31:0] d, bit fl);
    if (wv && addr_good(a)) begin
      p_idx[p_n] = idx_of(a);
      p_dat[p_n] = d;
      p_n++;
      if (p_n == 4) push_group(fl);
    end
    if (fl && p_n > 0) begin
      for (int i = p_n; i < 4; i++) begin
        p_idx[i] = idx_of('h1C54);
        p_dat[i] = 32'h0;
      end
      push_group(1'b1);
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request (write and/or flush), then the error flag check
  task automatic issue(bit wv, int a, logic [31:0] d, bit fl);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = wv;
    in_addr  = 16'(a);
    in_data  = d;
    flush    = fl;
    model(wv, a, d, fl);
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b0;
    check(err_pulse == (wv && !addr_good(a)), "R7 err_pulse",
          32'(err_pulse), 32'(wv && !addr_good(a)));
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && (rd_n != wr_n || out_valid); i++) @(negedge clk);
    check(rd_n == wr_n, "R5 words drained", 32'(rd_n), 32'(wr_n));
  endtask

  // output monitor and backpressure
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      unique case (rmode)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 3) != 0;
        default: rdy = lfsr[0];
      endcase
      out_ready = rdy;
      if (held) begin
        check(out_valid && out_data == held_w && out_last == held_l,
              "R10 hold under backpressure", out_data, held_w);
      end
      if (out_valid) check(!in_ready, "R11 in_ready low while sending", 32'(in_ready), 32'h0);
      held = out_valid && !rdy;
      held_w = out_data;
      held_l = out_last;
      if (out_valid && rdy) begin
        if (rd_n >= wr_n) begin
          check(1'b0, "R6 R9 unexpected word", out_data, 32'hx);
        end else begin
          if (rd_n % 5 == 0)
            check(out_data == exp_w[rd_n], "R2 R3 R4 header", out_data, exp_w[rd_n]);
          else
            check(out_data == exp_w[rd_n], "R5 R8 data word", out_data, exp_w[rd_n]);
          check(out_last == exp_l[rd_n], "R8 R12 last flag", 32'(out_last), 32'(exp_l[rd_n]));
        end
        rd_n++;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int bad_list [8] = '{'h1BFC, 'h1E00, 'h2BFC, 'h2E00, 'h1C01, 'h2C02, 'h0000, 'hFFFC};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; flush = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last && !err_pulse && in_ready, "R1 reset state",
          {28'h0, out_valid, out_last, err_pulse, in_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {30'h0, out_valid, in_ready}, 32'h1);

    // R6: three writes give no output
    for (int k = 0; k < 3; k++) issue(1'b1, 'h1C00 + 4*k, 32'h1111_0000 + k, 1'b0);
    repeat (8) @(negedge clk);
    check(!out_valid && in_ready, "R6 no output before fourth", 32'(out_valid), 32'h0);
    issue(1'b1, 'h2DFC, 32'hCAFE_F00D, 1'b0);
    drain();

    // exhaustive sweep of both windows with invalid writes interleaved
    for (int k = 0; k < 256; k++) begin
      int a;
      rmode = (k / 64) % 3;
      a = (k < 128) ? ('h1C00 + 4*k) : ('h2C00 + 4*(k - 128));
      if (k % 7 == 3) issue(1'b1, bad_list[(k / 7) % 8], 32'hDEAD_0000 + k, 1'b0);
      issue(1'b1, a, {16'(k), 16'(a)}, 1'b0);
    end
    drain();

    // R9: flush with nothing pending
    rmode = 2;
    issue(1'b0, 0, 32'h0, 1'b1);
    repeat (10) @(negedge clk);
    check(!out_valid && rd_n == wr_n, "R9 empty flush silent", 32'(out_valid), 32'h0);

    // R8: flush after 1, 2, 3 pending writes
    for (int n = 1; n <= 3; n++) begin
      for (int k = 0; k < n; k++) issue(1'b1, 'h2C00 + 16*k + 4*n, 32'h5A00_0000 + 32'(n*16 + k), 1'b0);
      issue(1'b0, 0, 32'h0, 1'b1);
      drain();
    end

    // R12: flush in the same cycle as the fourth write
    for (int k = 0; k < 3; k++) issue(1'b1, 'h1D00 + 4*k, 32'h7700_0000 + k, 1'b0);
    issue(1'b1, 'h2D00, 32'h7700_00FF, 1'b1);
    drain();

    // R7 R8: bad write together with flush, two pending
    rmode = 1;
    issue(1'b1, 'h1C10, 32'h0BAD_0001, 1'b0);
    issue(1'b1, 'h2C20, 32'h0BAD_0002, 1'b0);
    issue(1'b1, 'h3000, 32'h0BAD_0003, 1'b1);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule